// File: doc/BRIEF.md
# Period-Match Timer with Postscaler

This block is an 8-bit up-counter that advances on a clock-enable tick derived by dividing the system clock by four. The tick first passes through a selectable prescaler (1, 4 or 16). Instead of running to overflow, the counter returns to zero on the advance that follows a match with a programmable period register. That match is exported as a one-cycle pulse, which a serial port can use as a shift or baud clock. Each match also advances a 4-bit postscaler, and when the postscaler completes, a sticky interrupt flag is raised.

Software reaches four registers through a plain single-cycle register port. A write takes effect at the clock edge where `reg_wr` is high, and reads are combinational from `reg_addr`. Nothing flows through the block as a stream, so every pin is a plain control or status signal and there is no back-pressure. Writing the count or the control register restarts both scalers from zero. A control write leaves the count untouched.

Top module: `pm_timer`

## Requirements
- R1: The count starts at 00h and steps up by one on each prescaled tick. On the tick where the count equals the period register, it goes to 00h instead, and `match_o` is high for exactly the one following cycle, during which the count reads 00h.
- R2: The base tick occurs once every 4 system clocks. Control bits [1:0] select the prescale ratio: 00 gives 1, 01 gives 4, and 10 or 11 give 16. With period P, consecutive `match_o` pulses are 4 × ratio × (P+1) cycles apart.
- R3: After reset, the count reads 00h, the period reads FFh, the control register reads 00h, the flag reads 0, and `match_o` and `irq_o` are low.
- R4: Control bits [6:3] hold a postscale value N. The flag is set once for every N+1 match events, so consecutive sets are N+1 match intervals apart (for example, 64 cycles for N=15 and P=0 at ratio 1).
- R5: While control bit 2 (enable) is 0, the count does not change, except through a software write.
- R6: A count write appears in the count register in the next cycle, with no increment in the write cycle. It also clears the prescaler and the postscaler, so the next match with a loaded count equal to P at ratio 16 follows the write by 61 to 64 clock edges.
- R7: A control write clears the prescaler and the postscaler and leaves the count value unchanged.
- R8: The flag (register 3, bit 0, mirrored on `irq_o`) stays set until software writes 1 to bit 0 of register 3. If a set and a clear fall in the same cycle, the flag ends up set.
- R9: The register map is: address 0 is the count, 1 is the period, 2 is the control (bit 7 reads 0), and 3 is the flag. Every register reads back what was written, and the period may be rewritten while the timer runs.
- R10: A count above the period runs up to FFh, then to 00h, with no `match_o` pulse on that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 count, 1 period, 2 control, 3 flag |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| match_o | output | 1 | One-cycle pulse per period match, taken before the postscaler |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
A prescaler phase left over after a count or control write shows up as a first `match_o` that arrives early. For that reason, the bench times the first match after each clearing write against the 61 to 64 edge window, which exposes the error within one prescaled period. A postscaler that miscounts changes the spacing between flag sets by at least one whole match interval, which shows up on the second set. A wrong wrap comparison either skips the zero reading or raises a pulse on the FFh wrap, which shows up within one pass of the count.

// File: rtl/pm_timer_pkg.sv
package pm_timer_pkg;

  localparam int unsigned POST_W = 4;

  typedef enum logic [1:0] {
    A_COUNT  = 2'd0,
    A_PERIOD = 2'd1,
    A_CTRL   = 2'd2,
    A_FLAG   = 2'd3
  } reg_addr_e;

  // control register image, bit 6 down to bit 0
  typedef struct packed {
    logic [POST_W-1:0] post;  // postscale N, ratio N+1
    logic              en;    // counting enable
    logic [1:0]        pre;   // prescale select
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pm_tick_div.sv
module pm_tick_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign tick_o = (phase_q == LAST);
endmodule

// File: rtl/pm_prescaler.sv
module pm_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       inc_o
);
  localparam logic [PRE_W-1:0] TERM_1  = '0;
  localparam logic [PRE_W-1:0] TERM_4  = PRE_W'(3);
  localparam logic [PRE_W-1:0] TERM_16 = PRE_W'(15);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] term;
  logic             step;

  always_comb begin
    unique case (sel)
      2'b00:   term = TERM_1;
      2'b01:   term = TERM_4;
      default: term = TERM_16;
    endcase
  end

  assign step = tick && en && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (step)     cnt_q <= (cnt_q == term) ? '0 : cnt_q + 1'b1;
  end

  assign inc_o = step && (cnt_q == term);
endmodule

// File: rtl/pm_postscaler.sv
module pm_postscaler #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         evt,
  input  logic [W-1:0] last,
  output logic         fire_o
);
  logic [W-1:0] cnt_q;
  logic         step;

  assign step = evt && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (step)     cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
  end

  assign fire_o = step && (cnt_q == last);
endmodule

// File: rtl/pm_timer.sv
module pm_timer
  import pm_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned BASE_DIV = 4,
  parameter int unsigned PRE_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             match_o,
  output logic             irq_o
);
  localparam int unsigned PAD_CTRL = CNT_W - CTRL_W;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_q;
  logic             flag_q;
  logic             match_q;

  logic wr_cnt, wr_per, wr_ctrl, flag_clr;
  logic scal_clr;
  logic base_tick, pre_inc, at_period, match_evt, post_fire;
  logic ctrl_en;

  assign wr_cnt   = reg_wr && (reg_addr == A_COUNT);
  assign wr_per   = reg_wr && (reg_addr == A_PERIOD);
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign flag_clr = reg_wr && (reg_addr == A_FLAG) && reg_wdata[0];
  assign scal_clr = wr_cnt || wr_ctrl;
  assign ctrl_en  = ctrl_q.en;

  pm_tick_div #(.DIV(BASE_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (base_tick)
  );

  pm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (scal_clr),
    .tick  (base_tick),
    .en    (ctrl_q.en),
    .sel   (ctrl_q.pre),
    .inc_o (pre_inc)
  );

  assign at_period = (cnt_q == period_q);
  assign match_evt = pre_inc && at_period;

  pm_postscaler #(.W(POST_W)) u_post (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (scal_clr),
    .evt    (match_evt),
    .last   (ctrl_q.post),
    .fire_o (post_fire)
  );

  // count: a software write overrides any advance in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_cnt)  cnt_q <= reg_wdata;
    else if (pre_inc) cnt_q <= at_period ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      period_q <= '1;
    else if (wr_per) period_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= post_fire || (flag_q && !flag_clr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_evt;
  end

  always_comb begin
    unique case (reg_addr)
      A_COUNT:  reg_rdata = cnt_q;
      A_PERIOD: reg_rdata = period_q;
      A_CTRL:   reg_rdata = {{PAD_CTRL{1'b0}}, ctrl_q};
      default:  reg_rdata = {{(CNT_W-1){1'b0}}, flag_q};
    endcase
  end

  assign match_o = match_q;
  assign irq_o   = flag_q;
endmodule

// File: rtl/pm_timer_chk.sv
module pm_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ctrl_en,
  input logic             flag_q,
  input logic             post_fire,
  input logic             match_o
);
  logic w_cnt, w_ctrl, w_clr;
  assign w_cnt  = reg_wr && (reg_addr == 2'd0);
  assign w_ctrl = reg_wr && (reg_addr == 2'd2);
  assign w_clr  = reg_wr && (reg_addr == 2'd3) && reg_wdata[0];

  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> (cnt_q == '0));

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o);

  assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !w_cnt) |=> $stable(cnt_q));

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    w_cnt |=> (cnt_q == $past(reg_wdata)));

  assert_ctrl_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    w_ctrl |=> $stable(cnt_q));

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    post_fire |=> flag_q);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !w_clr) |=> flag_q);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (w_clr && !post_fire) |=> !flag_q);
endmodule

bind pm_timer pm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cnt_q     (cnt_q),
  .ctrl_en   (ctrl_en),
  .flag_q    (flag_q),
  .post_fire (post_fire),
  .match_o   (match_o)
);

// File: tb/pm_timer_test.sv
module pm_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       match_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pm_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .match_o(match_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic wait_match(output int k);
    k = 0;
    for (int i = 0; i < 2000 && !match_o; i++) begin
      @(negedge clk); k++;
    end
  endtask

  task automatic wait_irq(output int k);
    k = 0;
    for (int i = 0; i < 2000 && !irq_o; i++) begin
      @(negedge clk); k++;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(2'd0, v); check(v == 8'h00, "R3 count", v, 0);
    rd_reg(2'd1, v); check(v == 8'hFF, "R3 period", v, 255);
    rd_reg(2'd2, v); check(v == 8'h00, "R3 ctrl", v, 0);
    rd_reg(2'd3, v); check(v == 8'h00, "R3 flag", v, 0);
    check(!match_o && !irq_o, "R3 outputs", {match_o, irq_o}, 0);
  endtask

  task automatic t_regs_and_load();
    logic [7:0] v;
    wr_reg(2'd2, 8'h04);
    wr_reg(2'd0, 8'h37);
    rd_reg(2'd0, v); check(v == 8'h37, "R6 load", v, 8'h37);
    wr_reg(2'd1, 8'h5A);
    rd_reg(2'd1, v); check(v == 8'h5A, "R9 period rewrite", v, 8'h5A);
    wr_reg(2'd2, 8'hFB);
    rd_reg(2'd2, v); check(v == 8'h7B, "R9 ctrl bit7", v, 8'h7B);
  endtask

  task automatic t_hold_and_ctrl();
    logic [7:0] v;
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'h12);
    repeat (50) @(negedge clk);
    rd_reg(2'd0, v); check(v == 8'h12, "R5 hold", v, 8'h12);
    wr_reg(2'd2, 8'h7B);
    rd_reg(2'd0, v); check(v == 8'h12, "R7 count kept", v, 8'h12);
  endtask

  task automatic t_period(input logic [1:0] pre, input logic [7:0] p, input int exp);
    logic [7:0] v;
    int k;
    wr_reg(2'd1, p);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, {5'b00001, pre});
    wait_match(k);
    rd_reg(2'd0, v); check(match_o && v == 8'h00, "R1 zero on match", v, 0);
    @(negedge clk);
    check(!match_o, "R1 one-cycle pulse", match_o, 0);
    wait_match(k);
    check(k + 1 == exp, "R2 match spacing", k + 1, exp);
  endtask

  task automatic t_post(input logic [7:0] p, input logic [3:0] n, input int exp);
    int k;
    int j;
    wr_reg(2'd1, p);
    wr_reg(2'd2, {1'b0, n, 3'b100});
    wr_reg(2'd3, 8'h01);
    wait_irq(k);
    repeat (10) @(negedge clk);
    check(irq_o, "R8 sticky", irq_o, 1);
    wr_reg(2'd3, 8'h01);
    check(!irq_o, "R8 clear", irq_o, 0);
    wait_irq(j);
    check(j + 11 == exp, "R4 postscale spacing", j + 11, exp);
  endtask

  task automatic t_set_wins();
    int k;
    wr_reg(2'd1, 8'h03);
    wr_reg(2'd2, 8'h04);
    wr_reg(2'd3, 8'h01);
    wait_irq(k);
    wr_reg(2'd3, 8'h01);
    check(!irq_o, "R8 cleared", irq_o, 0);
    repeat (14) @(negedge clk);
    wr_reg(2'd3, 8'h01);
    check(irq_o, "R8 set wins", irq_o, 1);
  endtask

  task automatic t_scaler_clear(input bit by_ctrl);
    int k;
    wr_reg(2'd1, 8'h05);
    wr_reg(2'd2, 8'h06);
    if (by_ctrl) wr_reg(2'd0, 8'h05);
    repeat (20) @(negedge clk);
    if (by_ctrl) wr_reg(2'd2, 8'h06);
    else         wr_reg(2'd0, 8'h05);
    wait_match(k);
    k = k + 1;
    if (by_ctrl) check(k >= 62 && k <= 65, "R7 scalers cleared", k, 63);
    else         check(k >= 62 && k <= 65, "R6 scalers cleared", k, 63);
  endtask

  task automatic t_above_period();
    logic [7:0] v;
    bit seen = 1'b0;
    bit zero = 1'b0;
    wr_reg(2'd1, 8'h03);
    wr_reg(2'd2, 8'h04);
    wr_reg(2'd0, 8'hFE);
    for (int i = 0; i < 40 && !zero; i++) begin
      @(negedge clk);
      if (match_o) seen = 1'b1;
      rd_reg(2'd0, v);
      if (v == 8'h00) zero = 1'b1;
    end
    check(zero && !seen, "R10 wrap without match", {zero, seen}, 2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs_and_load();
    t_hold_and_ctrl();
    t_period(2'b00, 8'h03, 16);
    t_period(2'b01, 8'h03, 64);
    t_period(2'b10, 8'h02, 192);
    t_period(2'b11, 8'h01, 128);
    t_post(8'h03, 4'd2, 48);
    t_post(8'h00, 4'd15, 64);
    t_set_wins();
    t_scaler_clear(1'b0);
    t_scaler_clear(1'b1);
    t_above_period();
    finish_run();
  end
endmodule